// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Arbiter

This block sits between a CPU and its interrupt sources. Each of sixteen request lines has an individual enable. Most sources also need the global enable, but the top three priorities (the power-up/reset source and two non-maskable sources) bypass it. When the arbiter is idle and at least one request is eligible, it picks the highest-numbered eligible line. It registers that line's handler-table word address and raises an interrupt strobe. The strobe and address stay frozen until the CPU acknowledges.

The block also watches the instruction fetch bus. A valid fetch from the peripheral/register region or from an unmapped gap produces a one-cycle reset pulse. It also queues the top vector, which wins over every other pending request at the next arbitration. The gap boundaries are parameters, so one design covers several memory sizes. Sources that share a vector are ORed into one line before they reach this block.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Source i (0 to 15) maps to vector address 0xFFE0 + 2*i, so source 0 gives 0xFFE0 and source 15 gives 0xFFFE.
- R2: When several eligible requests are present, the one with the highest index is issued.
- R3: Sources 0 to 12 are eligible only when their request, their individual enable and the global enable are all 1.
- R4: Sources 13, 14 and 15 are eligible when their request and their individual enable are 1, whatever the global enable.
- R5: When the arbiter is idle and a request is eligible at a rising edge, irq_o is 1 after that edge with the matching vec_o. While irq_o is 0, vec_o reads 0x0000.
- R6: While irq_o is 1 and ack_i is 0, irq_o and vec_o keep their values, even if requests rise or fall.
- R7: ack_i sampled at 1 while irq_o is 1 clears irq_o and vec_o at that edge. A still-pending request is issued at the following edge.
- R8: A fetch with fetch_valid_i = 1 and an address in 0x0000 to 0x01FF makes fetch_rst_o 1 for exactly one cycle, after the sampling edge.
- R9: Fetches in 0x0300 to 0x0BFF or 0x1100 to 0x7FFF also cause the reset pulse. Legal addresses such as 0x0200, 0x0C00, 0x1000 and 0x8000 do not. An illegal address with fetch_valid_i = 0 is ignored.
- R10: An illegal fetch queues vector 0xFFFE, which needs no enable and beats every pending request. If it arrives while irq_o is 1, the current vector is held and 0xFFFE is issued on the edge after the acknowledge.
- R11: After reset, irq_o, vec_o and fetch_rst_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 16 | Request line per source, index = priority |
| ien_i | input | 16 | Individual enable per source |
| gie_i | input | 1 | Global enable for maskable sources |
| fetch_addr_i | input | 16 | Instruction fetch address |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| ack_i | input | 1 | CPU acknowledge of the issued vector |
| vec_o | output | 16 | Issued vector word address |
| irq_o | output | 1 | Interrupt strobe, held until acknowledged |
| fetch_rst_o | output | 1 | One-cycle reset pulse on an illegal fetch |

## Verification
The bench builds the block with its default parameters: sixteen sources, vector top at 0xFFFE, the bypass mask on the top three sources, and three forbidden windows (register space plus two gaps). With these values every vector address and the exact window edges can be reached. The bench probes addresses just inside and just outside each window. It also exercises the overlap of an illegal fetch with a pending or in-flight vector.

// File: rtl/irqarb_pkg.sv
// Shared types and helpers for the interrupt vector arbiter.
// Assumes vectors are word aligned and spaced one word apart.
package irqarb_pkg;

    // Handshake state of the vector issue register.
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

    // Word address of the slot for a given priority index.
    function automatic logic [15:0] slot_addr(input logic [15:0] base, input logic [15:0] idx);
        return base + (idx << 1);
    endfunction

endpackage

// File: rtl/irqarb_mask.sv
// Eligibility mask: a request counts when individually enabled, and
// additionally globally enabled unless its bit is set in BYPASS.
// Assumes request lines are already synchronous to clk.
module irqarb_mask #(
    parameter int          NUM_SRC = 16,
    parameter logic [15:0] BYPASS  = 16'hE000
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] ien_i,
    input  logic               gie_i,
    output logic [NUM_SRC-1:0] elig_o
);
    // One gate per source; the bypass bit picks the variant.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (BYPASS[g]) begin : g_nmi
            assign elig_o[g] = req_i[g] & ien_i[g];
        end else begin : g_mask
            assign elig_o[g] = req_i[g] & ien_i[g] & gie_i;
        end
    end
endmodule

// File: rtl/irqarb_prio.sv
// Fixed-priority encoder: highest set index wins.
// Assumes NUM_SRC fits the index width derived below.
module irqarb_prio #(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] elig_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Scan upward so the last (highest) hit is kept.
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (elig_i[k]) idx_o = IDX_W'(k);
        end
    end

    // Any eligible request at all.
    assign any_o = |elig_i;
endmodule

// File: rtl/irqarb_fetch_guard.sv
// Flags a valid fetch whose address lies in any forbidden window.
// Windows are inclusive [lo, hi] pairs packed into the parameters.
module irqarb_fetch_guard #(
    parameter int                   ADDR_W   = 16,
    parameter int                   NUM_WIN  = 3,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {16'h1100, 16'h0300, 16'h0000},
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {16'h7FFF, 16'h0BFF, 16'h01FF}
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              valid_i,
    output logic              bad_o
);
    logic [NUM_WIN-1:0] hit;

    // One comparator pair per window.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = WIN_LO[w*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] HI = WIN_HI[w*ADDR_W +: ADDR_W];
        assign hit[w] = (addr_i >= LO) && (addr_i <= HI);
    end

    // Only a qualified fetch counts.
    assign bad_o = valid_i && (|hit);
endmodule

// File: rtl/irq_vector_arbiter.sv
// Interrupt vector arbiter top. Issues one registered vector per
// acknowledge, holds it stable until ack, and converts illegal fetch
// addresses into a reset pulse plus a queued top-priority vector.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module irq_vector_arbiter #(
    parameter int          NUM_SRC = 16,
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] VEC_TOP = 16'hFFFE,
    parameter logic [15:0] BYPASS  = 16'hE000,
    parameter int          NUM_WIN = 3,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {16'h1100, 16'h0300, 16'h0000},
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {16'h7FFF, 16'h0BFF, 16'h01FF}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] ien_i,
    input  logic               gie_i,
    input  logic [ADDR_W-1:0]  fetch_addr_i,
    input  logic               fetch_valid_i,
    input  logic               ack_i,
    output logic [ADDR_W-1:0]  vec_o,
    output logic               irq_o,
    output logic               fetch_rst_o
);
    import irqarb_pkg::*;

    localparam int          IDX_W    = $clog2(NUM_SRC);
    localparam logic [15:0] VEC_BASE = VEC_TOP - 16'(2 * (NUM_SRC - 1));

    logic [NUM_SRC-1:0] elig;
    logic               any_elig;
    logic [IDX_W-1:0]   win_idx;
    logic               bad_fetch;
    arb_state_e         state_q;
    logic [ADDR_W-1:0]  vec_q;
    logic               rst_pend_q;
    logic               frst_q;
    logic               rst_want;
    logic               issue;
    logic [ADDR_W-1:0]  next_vec;

    irqarb_mask #(.NUM_SRC(NUM_SRC), .BYPASS(BYPASS)) mask_i (
        .req_i  (req_i),
        .ien_i  (ien_i),
        .gie_i  (gie_i),
        .elig_o (elig)
    );

    irqarb_prio #(.NUM_SRC(NUM_SRC)) prio_i (
        .elig_i (elig),
        .any_o  (any_elig),
        .idx_o  (win_idx)
    );

    irqarb_fetch_guard #(
        .ADDR_W (ADDR_W),
        .NUM_WIN(NUM_WIN),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) guard_i (
        .addr_i  (fetch_addr_i),
        .valid_i (fetch_valid_i),
        .bad_o   (bad_fetch)
    );

    // Decide whether to issue this cycle and which address to issue.
    always_comb begin
        rst_want = rst_pend_q | bad_fetch;
        issue    = (state_q == ARB_IDLE) && (rst_want || any_elig);
        if (rst_want) next_vec = ADDR_W'(VEC_TOP);
        else          next_vec = ADDR_W'(slot_addr(VEC_BASE, 16'(win_idx)));
    end

    // Issue register: load on issue, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            vec_q   <= '0;
        end else if (issue) begin
            state_q <= ARB_BUSY;
            vec_q   <= next_vec;
        end else if (state_q == ARB_BUSY && ack_i) begin
            state_q <= ARB_IDLE;
            vec_q   <= '0;
        end
    end

    // Queue an illegal-fetch reset vector until it has been issued.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pend_q <= 1'b0;
        else        rst_pend_q <= rst_want && !issue;
    end

    // One-cycle reset pulse per illegal fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) frst_q <= 1'b0;
        else        frst_q <= bad_fetch;
    end

    assign irq_o       = (state_q == ARB_BUSY);
    assign vec_o       = vec_q;
    assign fetch_rst_o = frst_q;
endmodule

// File: rtl/irqarb_chk.sv
// Protocol checker for the vector arbiter, attached by bind below.
module irqarb_chk #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] VEC_TOP  = 16'hFFFE,
    parameter logic [15:0] VEC_BASE = 16'hFFE0,
    parameter logic [15:0] PROT_HI  = 16'h01FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              fetch_valid_i,
    input logic [ADDR_W-1:0] fetch_addr_i,
    input logic [ADDR_W-1:0] vec_o,
    input logic              irq_o,
    input logic              fetch_rst_o
);
    // R6
    hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack_i |=> irq_o && $stable(vec_o));

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && ack_i |=> !irq_o);

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_o == '0);

    // R1
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o[0] == 1'b0) && (vec_o >= ADDR_W'(VEC_BASE)));

    // R8
    low_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i && (fetch_addr_i <= ADDR_W'(PROT_HI)) |=> fetch_rst_o);

    // R10
    rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i && (fetch_addr_i <= ADDR_W'(PROT_HI)) && !irq_o
        |=> irq_o && vec_o == ADDR_W'(VEC_TOP));
endmodule

bind irq_vector_arbiter irqarb_chk #(
    .ADDR_W  (ADDR_W),
    .VEC_TOP (VEC_TOP),
    .VEC_BASE(VEC_BASE),
    .PROT_HI (WIN_HI[ADDR_W-1:0])
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .fetch_valid_i(fetch_valid_i),
    .fetch_addr_i (fetch_addr_i),
    .vec_o        (vec_o),
    .irq_o        (irq_o),
    .fetch_rst_o  (fetch_rst_o)
);

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [15:0] ien = '0;
    logic        gie = 1'b0;
    logic [15:0] faddr = '0;
    logic        fvalid = 1'b0;
    logic        ack = 1'b0;
    logic [15:0] vec;
    logic        irq;
    logic        frst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ien_i(ien), .gie_i(gie),
        .fetch_addr_i(faddr), .fetch_valid_i(fvalid), .ack_i(ack),
        .vec_o(vec), .irq_o(irq), .fetch_rst_o(frst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Acknowledge the current vector and clear all requests.
    task automatic do_ack();
        ack = 1'b1;
        req = '0;
        step();
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 irq", irq, 0);
        chk("R11 vec", vec, 0);
        chk("R11 frst", frst, 0);
    endtask

    task automatic t_each_vector();
        gie = 1; ien = '1;
        for (int i = 0; i < 16; i++) begin
            req = 16'(1) << i;
            step();
            chk("R1 irq", irq, 1);
            chk("R1 vec", vec, 16'hFFE0 + 16'(2 * i));
            do_ack();
            chk("R5 idle vec", vec, 0);
        end
    endtask

    task automatic t_priority();
        gie = 1; ien = '1;
        req = 16'h0121; step();
        chk("R2 vec 8", vec, 16'hFFF0);
        do_ack();
        req = 16'h0003; step();
        chk("R2 vec 1", vec, 16'hFFE2);
        do_ack();
    endtask

    task automatic t_global_mask();
        gie = 0; ien = '1; req = 16'h1FFF;
        step(); step();
        chk("R3 gie blocks", irq, 0);
        gie = 1; ien = 16'hFFDF; req = 16'h0020;
        step(); step();
        chk("R3 ien blocks", irq, 0);
        ien = '1; step();
        chk("R3 enabled", vec, 16'hFFEA);
        do_ack();
    endtask

    task automatic t_nmi();
        gie = 0; ien = '1; req = 16'h4008;
        step();
        chk("R4 nmi14", vec, 16'hFFFC);
        do_ack();
        ien = 16'hBFFF; req = 16'h6000;
        step();
        chk("R4 nmi13", vec, 16'hFFFA);
        do_ack();
        ien = 16'h9FFF; req = 16'h6000;
        step(); step();
        chk("R4 ien blocks nmi", irq, 0);
        req = '0; ien = '1; gie = 1;
    endtask

    task automatic t_hold();
        req = 16'h0004; step();
        chk("R5 issue", vec, 16'hFFE4);
        req = 16'h1000;
        step(); step(); step();
        chk("R6 irq held", irq, 1);
        chk("R6 vec held", vec, 16'hFFE4);
        ack = 1; step(); ack = 0;
        chk("R7 drop", irq, 0);
        step();
        chk("R7 next irq", irq, 1);
        chk("R7 next vec", vec, 16'hFFF8);
        do_ack();
    endtask

    task automatic fetch_probe(input logic [15:0] a, input logic v, input logic bad);
        faddr = a; fvalid = v;
        step();
        fvalid = 0;
        chk(bad ? "R8/R9 rst pulse" : "R9 no rst", frst, bad);
        chk("R10 vec on fetch", vec, bad ? 16'hFFFE : 16'h0000);
        step();
        chk("R8 pulse ends", frst, 0);
        if (irq) do_ack();
    endtask

    task automatic t_fetch();
        req = '0;
        fetch_probe(16'h0000, 1, 1);
        fetch_probe(16'h01FF, 1, 1);
        fetch_probe(16'h0200, 1, 0);
        fetch_probe(16'h0300, 1, 1);
        fetch_probe(16'h0BFF, 1, 1);
        fetch_probe(16'h0C00, 1, 0);
        fetch_probe(16'h1000, 1, 0);
        fetch_probe(16'h1100, 1, 1);
        fetch_probe(16'h7FFF, 1, 1);
        fetch_probe(16'h8000, 1, 0);
        fetch_probe(16'h0100, 0, 0);
    endtask

    task automatic t_precedence();
        gie = 0; ien = 16'h7FFF; req = 16'h4000;
        faddr = 16'h0050; fvalid = 1;
        step(); fvalid = 0;
        chk("R10 beats nmi", vec, 16'hFFFE);
        ack = 1; step(); ack = 0;
        step();
        chk("R10 nmi after", vec, 16'hFFFC);
        do_ack();
        gie = 1; ien = '1; req = 16'h0008; step();
        chk("R10 busy first", vec, 16'hFFE6);
        faddr = 16'h0400; fvalid = 1; step(); fvalid = 0;
        chk("R10 busy pulse", frst, 1);
        chk("R10 busy held", vec, 16'hFFE6);
        ack = 1; step(); ack = 0;
        step();
        chk("R10 queued rst", vec, 16'hFFFE);
        do_ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_each_vector();
        t_priority();
        t_global_mask();
        t_nmi();
        t_hold();
        t_fetch();
        t_precedence();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule